// File: doc/BRIEF.md
# Dithered PWM/PDM Output Generator

A single-channel pulse generator that turns a signed fixed-point duty command into a pulse train. It steps once for every cycle on which the tick-enable input is high. A nonzero period setting selects pulse-width modulation, and the setting gives the period length in ticks. A period of zero selects pulse-density modulation, in which a fractional error accumulator decides on every tick whether the output is high.

In PWM operation, each period gets a whole number of high ticks, and those high ticks come first in the period. With dithering off, the count is rounded to the nearest level. With dithering on, the rounding remainder carries from one period to the next, so the long-run average follows the command to the full fractional resolution even when a period is only a few ticks long.

The duty magnitude is clamped between a floor and a ceiling before use. A 2-bit mode input chooses one of three pin arrangements: a single output, a pulse plus direction pair, or an up/down pair for the two halves of an H-bridge. The command, the limits, the mode and the period are taken in only at a period boundary, so a period already in progress always finishes as it started.

Top module: `pwm_dither_gen`

## Requirements
- R1: While `en` is low, `pwm`, `dir`, `up` and `down` are all low, whatever `duty_min` holds. Raising `en` starts a fresh period with a cleared error accumulator on the next tick.
- R2: In mode 0 (single), `pwm` carries the clamped duty of a non-negative command. A negative command is treated as zero duty, which yields the `duty_min` duty. `dir`, `up` and `down` stay low.
- R3: In mode 1 (pulse plus direction), `pwm` carries the clamped duty of the command magnitude. `dir` is 1 for a negative command and 0 otherwise. `up` and `down` stay low.
- R4: In mode 2 (up/down), the waveform appears on `up` for a non-negative command and on `down` for a negative one, and the other pin of the pair stays low. `pwm` and `dir` stay low. In mode 3, every pin stays low.
- R5: Full scale is 4096 (2^FRAC_W). The duty used is |cmd| capped at `duty_max`, then raised to `duty_min` if it is below it, so the floor wins when the limits cross. The result is then capped at 4096.
- R6: The period is a whole number of ticks. A setting of 1 behaves as 2. A period with h high ticks shows them on its first h ticks.
- R7: With `dither` = 0, every period holds round(d·P/4096) high ticks, where a half rounds up.
- R8: With `dither` = 1, the total number of high ticks over K whole periods after enable is floor(K·d·P/4096).
- R9: With `period` = 0, the total number of high ticks over N ticks after enable is floor(N·d/4096), and `dither` has no effect.
- R10: A change to the command or limits in the middle of a period does not alter that period. It takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Advances the generator by one time step |
| en | input | 1 | Output enable; low forces all pins low and restarts |
| duty_cmd | input | CMD_W | Signed duty command, 4096 = 100 % |
| period | input | PER_W | Period in ticks; 0 selects PDM |
| dither | input | 1 | Carries the rounding error between PWM periods |
| out_mode | input | 2 | 0 single, 1 pulse+direction, 2 up/down, 3 off |
| duty_min | input | FRAC_W+1 | Duty floor |
| duty_max | input | FRAC_W+1 | Duty ceiling |
| pwm | output | 1 | Pulse output (modes 0 and 1) |
| dir | output | 1 | Direction output (mode 1) |
| up | output | 1 | Positive-half pulse (mode 2) |
| down | output | 1 | Negative-half pulse (mode 2) |

## Verification
The hardest state to reach is the dither accumulator carrying a remainder across many short periods. A per-period check cannot see that remainder, because it only shows up as an occasional extra high tick. The bench therefore drops `en` before every case to zero the accumulator. It then counts high ticks over an exact whole number of periods and compares the total with the floor of the ideal product. Any loss or double count of the remainder changes that total. The random cases use short periods and odd duty values, so the carry-over is exercised often.

// File: rtl/pwm_gen_pkg.sv
// Package: shared types for the dithered PWM/PDM generator.
// Assumes: nothing; it holds types only.
package pwm_gen_pkg;

    // Pin arrangement selected by out_mode
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DIR    = 2'd1,
        MODE_UPDN   = 2'd2,
        MODE_OFF    = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/pwm_duty_clamp.sv
// Module: pwm_duty_clamp
// Purpose: turns a signed command into an unsigned duty magnitude.
// The magnitude is capped by the ceiling, raised to the floor (the floor
// wins when the limits cross) and finally capped at full scale.
// Assumes: CMD_W > FRAC_W + 1; purely combinational.
module pwm_duty_clamp #(
    parameter int CMD_W  = 16,
    parameter int FRAC_W = 12
) (
    input  logic signed [CMD_W-1:0] cmd,
    input  logic                    zero_neg,
    input  logic [FRAC_W:0]         lim_min,
    input  logic [FRAC_W:0]         lim_max,
    output logic [FRAC_W:0]         duty,
    output logic                    neg
);
    localparam logic [FRAC_W:0] FULL = (FRAC_W+1)'(1) << FRAC_W;

    logic [CMD_W-1:0] mag;
    logic [CMD_W-1:0] use_mag;
    logic [FRAC_W:0]  capped;
    logic [FRAC_W:0]  floored;

    // Magnitude, with negative commands zeroed when the mode asks for it
    always_comb begin
        neg     = cmd[CMD_W-1];
        mag     = neg ? (~cmd + CMD_W'(1)) : cmd;
        use_mag = (zero_neg && neg) ? '0 : mag;
    end

    // Ceiling, then floor, then full-scale cap
    always_comb begin
        capped  = (use_mag > CMD_W'(lim_max)) ? lim_max : use_mag[FRAC_W:0];
        floored = (capped < lim_min) ? lim_min : capped;
        duty    = (floored > FULL) ? FULL : floored;
    end
endmodule

// File: rtl/pwm_level_acc.sv
// Module: pwm_level_acc
// Purpose: decides the high-tick count of each PWM period, or the bit of
// each PDM tick. A fractional accumulator holds the rounding remainder.
// Assumes: duty <= 2^FRAC_W; period_eff >= 2 whenever pdm is low.
module pwm_level_acc #(
    parameter int FRAC_W = 12,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              pdm,
    input  logic              dither,
    input  logic [FRAC_W:0]   duty,
    input  logic [PER_W-1:0]  period_eff,
    output logic [PER_W-1:0]  hi_ticks,
    output logic              pdm_bit
);
    localparam int PW = FRAC_W + 1 + PER_W;
    localparam int DW = FRAC_W + 2;
    localparam logic [PW-1:0] HALF  = PW'(1) << (FRAC_W - 1);
    localparam logic [DW-1:0] FULLD = DW'(1) << FRAC_W;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_d;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     psum;
    logic [PW-1:0]     rnd;
    logic [DW-1:0]     dsum;

    // PWM level: the carried sum with dither, the rounded product without
    always_comb begin
        prod     = PW'(duty) * PW'(period_eff);
        psum     = prod + PW'(acc_q);
        rnd      = prod + HALF;
        hi_ticks = dither ? PER_W'(psum >> FRAC_W) : PER_W'(rnd >> FRAC_W);
    end

    // PDM bit: high when the accumulator passes full scale
    always_comb begin
        dsum    = DW'(duty) + DW'(acc_q);
        pdm_bit = (dsum >= FULLD);
    end

    // Next remainder for the mode in use
    always_comb begin
        if (pdm)
            acc_d = pdm_bit ? FRAC_W'(dsum - FULLD) : FRAC_W'(dsum);
        else if (dither)
            acc_d = psum[FRAC_W-1:0];
        else
            acc_d = '0;
    end

    // Remainder register, cleared by reset or by disable
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc_q <= '0;
        else if (step)
            acc_q <= acc_d;
    end

    AST_HI_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pdm) |-> (hi_ticks <= period_eff)); // R6
    AST_NODITHER_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pdm && !dither) |=> (acc_q == '0)); // R7
endmodule

// File: rtl/pwm_period_timer.sv
// Module: pwm_period_timer
// Purpose: counts ticks within a PWM period and produces the registered
// waveform. It flags the boundary tick on which new settings are taken.
// Assumes: hi_ticks and pdm_bit are valid during the boundary tick.
module pwm_period_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [PER_W-1:0] period_in,
    input  logic [PER_W-1:0] hi_ticks,
    input  logic             pdm_bit,
    output logic             boundary,
    output logic             pdm_live,
    output logic [PER_W-1:0] period_eff,
    output logic             wave
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] hi_q;

    // Effective period: 0 means PDM, 1 is raised to the 2-tick minimum
    always_comb begin
        pdm_live   = (period_in == '0);
        period_eff = (period_in == PER_W'(1)) ? PER_W'(2) : period_in;
        boundary   = tick && (cnt_q == '0);
    end

    // Phase counter and waveform register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            per_q <= '0;
            hi_q  <= '0;
            wave  <= 1'b0;
        end else if (tick) begin
            if (cnt_q == '0) begin
                if (pdm_live) begin
                    wave <= pdm_bit;
                end else begin
                    wave  <= (hi_ticks != '0);
                    hi_q  <= hi_ticks;
                    per_q <= period_eff;
                    cnt_q <= PER_W'(1);
                end
            end else begin
                wave  <= (cnt_q < hi_q);
                cnt_q <= (cnt_q == per_q - PER_W'(1)) ? '0 : cnt_q + PER_W'(1);
            end
        end
    end

    AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (per_q >= PER_W'(2))); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q < per_q)); // R6
    AST_PDM_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (tick && pdm_live && cnt_q == '0) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/pwm_dither_gen.sv
// Module: pwm_dither_gen (top)
// Purpose: single-channel PWM/PDM generator with clamping, optional dither
// and three pin arrangements. Settings are taken at period boundaries.
// Assumes: tick is a single-cycle enable; reset is synchronous, active low.
module pwm_dither_gen
    import pwm_gen_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int FRAC_W = 12,
    parameter int PER_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    en,
    input  logic signed [CMD_W-1:0] duty_cmd,
    input  logic [PER_W-1:0]        period,
    input  logic                    dither,
    input  logic [1:0]              out_mode,
    input  logic [FRAC_W:0]         duty_min,
    input  logic [FRAC_W:0]         duty_max,
    output logic                    pwm,
    output logic                    dir,
    output logic                    up,
    output logic                    down
);
    logic             clear;
    logic [FRAC_W:0]  duty;
    logic             neg;
    logic             boundary;
    logic             pdm_live;
    logic [PER_W-1:0] period_eff;
    logic [PER_W-1:0] hi_ticks;
    logic             pdm_bit;
    logic             wave;
    pin_mode_e        mode_live;
    pin_mode_e        mode_q;
    logic             neg_q;

    // Disable clears phase and remainder
    always_comb begin
        clear     = !en;
        mode_live = pin_mode_e'(out_mode);
    end

    pwm_duty_clamp #(.CMD_W(CMD_W), .FRAC_W(FRAC_W)) u_clamp (
        .cmd      (duty_cmd),
        .zero_neg (mode_live == MODE_SINGLE),
        .lim_min  (duty_min),
        .lim_max  (duty_max),
        .duty     (duty),
        .neg      (neg)
    );

    pwm_level_acc #(.FRAC_W(FRAC_W), .PER_W(PER_W)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .step       (boundary),
        .pdm        (pdm_live),
        .dither     (dither),
        .duty       (duty),
        .period_eff (period_eff),
        .hi_ticks   (hi_ticks),
        .pdm_bit    (pdm_bit)
    );

    pwm_period_timer #(.PER_W(PER_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .tick       (tick),
        .period_in  (period),
        .hi_ticks   (hi_ticks),
        .pdm_bit    (pdm_bit),
        .boundary   (boundary),
        .pdm_live   (pdm_live),
        .period_eff (period_eff),
        .wave       (wave)
    );

    // Mode and sign held for the whole period
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mode_q <= MODE_OFF;
            neg_q  <= 1'b0;
        end else if (boundary) begin
            mode_q <= mode_live;
            neg_q  <= neg;
        end
    end

    // Pin steering per mode, gated by enable
    always_comb begin
        pwm  = 1'b0;
        dir  = 1'b0;
        up   = 1'b0;
        down = 1'b0;
        if (en) begin
            case (mode_q)
                MODE_SINGLE: pwm = wave;
                MODE_DIR: begin
                    pwm = wave;
                    dir = neg_q;
                end
                MODE_UPDN: begin
                    up   = wave && !neg_q;
                    down = wave && neg_q;
                end
                default: ;
            endcase
        end
    end

    AST_UPDN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && down)); // R4
    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wave); // R1
    AST_SINGLE_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SINGLE) |-> !dir); // R2
endmodule

// File: tb/sim_pwm_dither_gen.sv
module sim_pwm_dither_gen;
    localparam int CMD_W  = 16;
    localparam int FRAC_W = 12;
    localparam int PER_W  = 8;
    localparam longint FULL = 4096;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    tick = 1'b0;
    logic                    en = 1'b0;
    logic signed [CMD_W-1:0] duty_cmd = '0;
    logic [PER_W-1:0]        period = '0;
    logic                    dither = 1'b0;
    logic [1:0]              out_mode = 2'd0;
    logic [FRAC_W:0]         duty_min = '0;
    logic [FRAC_W:0]         duty_max = '0;
    logic pwm, dir, up, down;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int c_pwm, c_dir, c_up, c_down;

    always #2.5 clk = ~clk;

    pwm_dither_gen #(.CMD_W(CMD_W), .FRAC_W(FRAC_W), .PER_W(PER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .duty_cmd(duty_cmd),
        .period(period), .dither(dither), .out_mode(out_mode),
        .duty_min(duty_min), .duty_max(duty_max),
        .pwm(pwm), .dir(dir), .up(up), .down(down)
    );

    task automatic chk(input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic longint exp_duty(input longint cmd, input int mode,
                                        input longint mn, input longint mx);
        longint m;
        m = (cmd < 0) ? -cmd : cmd;
        if (mode == 0 && cmd < 0) m = 0;
        if (m > mx) m = mx;
        if (m < mn) m = mn;
        if (m > FULL) m = FULL;
        return m;
    endfunction

    function automatic longint exp_total(input longint d, input int per, input bit dth,
                                         input longint units);
        longint p;
        if (per == 0) return (units * d) / FULL;
        p = (per == 1) ? 2 : per;
        if (dth) return (units * d * p) / FULL;
        return units * ((d * p + FULL / 2) / FULL);
    endfunction

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        c_pwm  += int'(pwm);
        c_dir  += int'(dir);
        c_up   += int'(up);
        c_down += int'(down);
    endtask

    task automatic clear_counts();
        c_pwm = 0; c_dir = 0; c_up = 0; c_down = 0;
    endtask

    task automatic restart();
        @(negedge clk) en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_case(input string tag, input int cmd, input int per, input bit dth,
                            input int mode, input int mn, input int mx, input int units);
        longint d, tot, ticks;
        bit ng;
        restart();
        duty_cmd = CMD_W'(cmd);
        period = PER_W'(per);
        dither = dth;
        out_mode = 2'(mode);
        duty_min = (FRAC_W+1)'(mn);
        duty_max = (FRAC_W+1)'(mx);
        @(negedge clk) en = 1'b1;
        clear_counts();
        ticks = (per == 0) ? units : units * ((per == 1) ? 2 : per);
        for (longint i = 0; i < ticks; i++) tick_once();
        d = exp_duty(cmd, mode, mn, mx);
        tot = exp_total(d, per, dth, units);
        ng = (cmd < 0);
        case (mode)
            0: begin
                chk({tag, " R2 pwm count"}, c_pwm, tot);
                chk({tag, " R2 other pins"}, c_dir + c_up + c_down, 0);
            end
            1: begin
                chk({tag, " R3 pwm count"}, c_pwm, tot);
                chk({tag, " R3 dir count"}, c_dir, ng ? ticks : 0);
                chk({tag, " R3 up/down"}, c_up + c_down, 0);
            end
            2: begin
                chk({tag, " R4 up count"}, c_up, ng ? 0 : tot);
                chk({tag, " R4 down count"}, c_down, ng ? tot : 0);
                chk({tag, " R4 pwm/dir"}, c_pwm + c_dir, 0);
            end
            default: chk({tag, " R4 mode3 all low"}, c_pwm + c_dir + c_up + c_down, 0);
        endcase
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset pwm R1", pwm, 0);
        chk("reset pins R1", dir + up + down, 0);

        // R1: disabled with a full floor stays quiet
        duty_min = 13'd4096; duty_max = 13'd4096; period = 8'd10; out_mode = 2'd1;
        duty_cmd = -16'sd3000;
        clear_counts();
        repeat (20) tick_once();
        chk("R1 disabled pins", c_pwm + c_dir + c_up + c_down, 0);

        // R7: 0.8 of 10 ticks, no dither
        run_case("nodither", 3277, 10, 0, 0, 0, 4096, 8);
        // R7: half rounds up (2048*3/4096 = 1.5 -> 2)
        run_case("R7 half", 2048, 3, 0, 1, 0, 4096, 6);
        // R8: dither with a 3-tick period and a fine duty
        run_case("R8 dither", 1000, 3, 1, 0, 0, 4096, 40);
        // R9: PDM ignores dither
        run_case("R9 pdm d0", 1234, 0, 0, 2, 0, 4096, 500);
        run_case("R9 pdm d1", 1234, 0, 1, 2, 0, 4096, 500);
        // R2: negative in single mode gives the floor
        run_case("R2 neg floor", -3000, 8, 0, 0, 1024, 4096, 6);
        // R5: ceiling, crossed limits, over full scale
        run_case("R5 ceil", 4000, 16, 1, 1, 0, 2048, 6);
        run_case("R5 crossed", 500, 16, 1, 2, 3000, 1000, 6);
        run_case("R5 overfull", -20000, 8, 0, 2, 0, 4500, 5);
        // R6: period 1 behaves as 2
        run_case("R6 per1", 2048, 1, 0, 0, 0, 4096, 10);
        // R4: mode 3 silent
        run_case("R4 off", 3000, 5, 0, 3, 2000, 4096, 5);

        // R10: mid-period command change does not alter that period
        restart();
        duty_cmd = 16'sd3277; period = 8'd10; dither = 0; out_mode = 2'd0;
        duty_min = '0; duty_max = 13'd4096;
        @(negedge clk) en = 1'b1;
        clear_counts();
        repeat (3) tick_once();
        duty_cmd = 16'sd0;
        repeat (7) tick_once();
        chk("R10 old period kept", c_pwm, 8);
        clear_counts();
        repeat (10) tick_once();
        chk("R10 new period used", c_pwm, 0);

        // Random cases (R2..R9)
        for (int k = 0; k < 24; k++) begin
            int cmd, per, md, mn, mx;
            bit dth;
            cmd = int'($urandom_range(0, 12000)) - 6000;
            per = int'($urandom_range(0, 37));
            dth = 1'($urandom_range(0, 1));
            md  = int'($urandom_range(0, 3));
            mn  = int'($urandom_range(0, 1500));
            mx  = int'($urandom_range(1500, 4600));
            run_case($sformatf("rand%0d", k), cmd, per, dth, md, mn, mx,
                     (per == 0) ? 400 : 12);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule